// File: doc/BRIEF.md
# SIMD Floating-Point Compare Unit

This unit compares two 128-bit vector operands lane by lane. A 3-bit predicate code selects the comparison. In packed-single mode the operands hold four IEEE-754 binary32 lanes. In scalar-double mode only the low binary64 lane is compared. Each compared lane writes an all-ones mask when the predicate holds and an all-zeros mask when it does not. The comparison is NaN-aware: an unordered pair gives a defined true or false for every predicate.

Alongside the mask, the unit reports two exception flags, invalid-operation and denormal-operand. Each flag is the OR over the compared lanes. In scalar mode, the upper 64 bits of the result pass through unchanged from the first operand, so the result can be written back over that operand as a whole register.

The result and flags are registered. They appear one cycle after the valid strobe. Masking of exceptions, trapping, flush or denormals-are-zero handling, and instruction decode belong to the surrounding pipeline.

Top module: `fp_vec_compare`

## Requirements
- R1: The predicate is `imm[2:0]`. Bits 7..3 of `imm` have no effect on the result or the flags.
- R2: For ordered operands, the predicate encodings are: 0 equal, 1 less-than, 2 less-or-equal, 4 not-equal, 5 not-less-than, 6 not-less-or-equal. Positive and negative zero compare equal. Negative values order below positive values, and infinities order beyond every finite value of their sign.
- R3: When either operand of a lane is a NaN, predicates 0, 1, 2 and 7 give false, and predicates 3, 4, 5 and 6 give true. A NaN has an all-ones exponent and a nonzero fraction.
- R4: Predicate 7 (ordered) is true exactly when neither operand is a NaN. Predicate 3 (unordered) is true exactly when at least one operand is a NaN.
- R5: A quiet NaN has a fraction MSB of 1. It raises `inv_flag` only under predicates 1, 2, 5 and 6.
- R6: A signaling NaN has a fraction MSB of 0 and a nonzero fraction. It raises `inv_flag` under every predicate.
- R7: An operand with a zero exponent and a nonzero fraction, in any compared lane, raises `den_flag`.
- R8: When `dbl_mode`=0, the four lanes `[32i+31:32i]` are compared independently. Each lane's result is 32 ones or 32 zeros, and each flag is the OR over the four lanes.
- R9: When `dbl_mode`=1, only bits 63..0 are compared. Bits 63..0 of the result are 64 ones or 64 zeros. Values in bits 127..64 of either operand do not affect the flags.
- R10: When `dbl_mode`=1, `res[127:64]` equals `src_a[127:64]` as it was at the strobe.
- R11: `res`, `inv_flag` and `den_flag` update on the clock edge that samples `in_valid`=1. `res_valid` is high for exactly the cycle after each strobe.
- R12: A synchronous `rst` clears `res`, `res_valid`, `inv_flag` and `den_flag` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| dbl_mode | input | 1 | 0: four binary32 lanes, 1: low binary64 lane only |
| imm | input | 8 | Predicate immediate; bits 2..0 used |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand |
| res | output | 128 | Registered lane masks |
| res_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| inv_flag | output | 1 | Invalid-operation flag |
| den_flag | output | 1 | Denormal-operand flag |

## Verification
The bench targets several specific corner cases, each paired with the bug it would expose:
- Pairs of signed zeros: a plain bit compare would call +0 and -0 unequal.
- Two negative operands: a design that forgets to invert the magnitude order would reverse less-than.
- Quiet and signaling NaNs under every predicate: a wrong invalid rule would flag a quiet NaN under equal, or miss a signaling NaN under ordered, and a wrong polarity would return true for less-than on NaN.
- Scalar mode with NaNs and denormals in the upper half: a design that ORs flags over all lanes, or that overwrites the upper half, would show a false flag or a corrupted pass-through.
- Immediates with the high bits set: a design that decodes more than three bits would change the predicate.

// File: rtl/fp_vec_compare.sv
module fp_vec_compare #(
  parameter int SP_LANES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         dbl_mode,
  input  logic [7:0]   imm,
  input  logic [127:0] src_a,
  input  logic [127:0] src_b,
  output logic [127:0] res,
  output logic         res_valid,
  output logic         inv_flag,
  output logic         den_flag
);
  localparam int SPW = 32;
  localparam int DPW = 64;

  logic [2:0] pred;
  assign pred = imm[2:0];

  // {nan, snan, denormal}
  function automatic logic [2:0] cls_sp(input logic [SPW-1:0] v);
    logic n;
    n = (&v[30:23]) && (|v[22:0]);
    return {n, n && !v[22], (~|v[30:23]) && (|v[22:0])};
  endfunction

  function automatic logic [2:0] cls_dp(input logic [DPW-1:0] v);
    logic n;
    n = (&v[62:52]) && (|v[51:0]);
    return {n, n && !v[51], (~|v[62:52]) && (|v[51:0])};
  endfunction

  // {equal, less}
  function automatic logic [1:0] rel_sp(input logic [SPW-1:0] a, input logic [SPW-1:0] b);
    logic z, l;
    z = (~|a[30:0]) && (~|b[30:0]);
    if (z)                l = 1'b0;
    else if (a[31] != b[31]) l = a[31];
    else if (!a[31])      l = a[30:0] < b[30:0];
    else                  l = a[30:0] > b[30:0];
    return {z || (a == b), l};
  endfunction

  function automatic logic [1:0] rel_dp(input logic [DPW-1:0] a, input logic [DPW-1:0] b);
    logic z, l;
    z = (~|a[62:0]) && (~|b[62:0]);
    if (z)                l = 1'b0;
    else if (a[63] != b[63]) l = a[63];
    else if (!a[63])      l = a[62:0] < b[62:0];
    else                  l = a[62:0] > b[62:0];
    return {z || (a == b), l};
  endfunction

  // {true, invalid, denormal}
  function automatic logic [2:0] judge(input logic [2:0] p, input logic [2:0] ca,
                                       input logic [2:0] cb, input logic [1:0] r);
    logic ord, t, q_inv;
    ord = !ca[2] && !cb[2];
    case (p)
      3'd0: t = ord && r[1];
      3'd1: t = ord && r[0];
      3'd2: t = ord && (r[1] || r[0]);
      3'd3: t = !ord;
      3'd4: t = !(ord && r[1]);
      3'd5: t = !(ord && r[0]);
      3'd6: t = !(ord && (r[1] || r[0]));
      default: t = ord;
    endcase
    q_inv = !ord && (p[1:0] == 2'd1 || p[1:0] == 2'd2);
    return {t, ca[1] || cb[1] || q_inv, ca[0] || cb[0]};
  endfunction

  logic [SP_LANES*SPW-1:0] sp_mask;
  logic [SP_LANES-1:0]     sp_inv, sp_den;

  for (genvar i = 0; i < SP_LANES; i++) begin : g_lane
    logic [SPW-1:0] la, lb;
    logic [2:0]     j;
    assign la = src_a[i*SPW +: SPW];
    assign lb = src_b[i*SPW +: SPW];
    assign j  = judge(pred, cls_sp(la), cls_sp(lb), rel_sp(la, lb));
    assign sp_mask[i*SPW +: SPW] = {SPW{j[2]}};
    assign sp_inv[i] = j[1];
    assign sp_den[i] = j[0];
  end

  logic [2:0] dj;
  assign dj = judge(pred, cls_dp(src_a[DPW-1:0]), cls_dp(src_b[DPW-1:0]),
                    rel_dp(src_a[DPW-1:0], src_b[DPW-1:0]));

  logic [127:0] nxt_res;
  logic         nxt_inv, nxt_den;
  assign nxt_res = dbl_mode ? {src_a[127:DPW], {DPW{dj[2]}}} : sp_mask;
  assign nxt_inv = dbl_mode ? dj[1] : |sp_inv;
  assign nxt_den = dbl_mode ? dj[0] : |sp_den;

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      res_valid <= 1'b0;
      inv_flag  <= 1'b0;
      den_flag  <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res      <= nxt_res;
        inv_flag <= nxt_inv;
        den_flag <= nxt_den;
      end
    end
  end
endmodule

// File: rtl/fp_vec_compare_chk.sv
module fp_vec_compare_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         dbl_mode,
  input logic [127:0] src_a,
  input logic [127:0] res,
  input logic         res_valid
);
  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  assert_valid_drops_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);
  assert_upper_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dbl_mode) |=> res[127:64] == $past(src_a[127:64]));
  assert_dp_mask_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dbl_mode) |=> (res[63:0] == '0 || res[63:0] == '1));
  assert_sp_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dbl_mode) |=>
      ((res[31:0]   == '0 || res[31:0]   == '1) &&
       (res[63:32]  == '0 || res[63:32]  == '1) &&
       (res[95:64]  == '0 || res[95:64]  == '1) &&
       (res[127:96] == '0 || res[127:96] == '1)));
  assert_reset_clears_R12: assert property (@(posedge clk)
    rst |=> (res == '0 && !res_valid));
endmodule

bind fp_vec_compare fp_vec_compare_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dbl_mode(dbl_mode),
  .src_a(src_a), .res(res), .res_valid(res_valid)
);

// File: tb/sim_fp_vec_compare.sv
module sim_fp_vec_compare;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic dbl_mode = 1'b0;
  logic [7:0] imm = '0;
  logic [127:0] src_a = '0, src_b = '0;
  logic [127:0] res;
  logic res_valid, inv_flag, den_flag;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fp_vec_compare u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .dbl_mode(dbl_mode),
    .imm(imm), .src_a(src_a), .src_b(src_b), .res(res), .res_valid(res_valid),
    .inv_flag(inv_flag), .den_flag(den_flag));

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  function automatic real sp2r(input logic [31:0] v);
    real m;
    int e;
    e = int'(v[30:23]);
    if (e == 255) m = 1.0e300;
    else if (e == 0) m = real'(v[22:0]) * (2.0 ** (-149));
    else m = (real'(v[22:0]) + 8388608.0) * (2.0 ** (e - 150));
    return v[31] ? -m : m;
  endfunction

  function automatic bit truth(input int p, input bit un, input bit lt, input bit eq);
    case (p)
      0: return !un && eq;
      1: return !un && lt;
      2: return !un && (lt || eq);
      3: return un;
      4: return un || !eq;
      5: return un || !lt;
      6: return un || !(lt || eq);
      default: return !un;
    endcase
  endfunction

  function automatic bit qinv_pred(input int p);
    return p == 1 || p == 2 || p == 5 || p == 6;
  endfunction

  function automatic logic [31:0] gen32(input logic [31:0] other);
    int s;
    logic sg;
    s = int'($urandom_range(0, 10));
    sg = 1'($urandom);
    case (s)
      0, 1, 2: return {sg, 8'($urandom_range(1, 254)), 23'($urandom)};
      3: return {sg, 31'd0};
      4: return {sg, 8'hff, 23'd0};
      5: return {sg, 8'hff, 1'b1, 22'($urandom)};
      6: return {sg, 8'hff, 1'b0, 22'($urandom) | 22'd1};
      7: return {sg, 8'h00, 23'($urandom) | 23'd1};
      8: return other;
      9: return {~other[31], other[30:0]};
      default: return {other[31:1], ~other[0]};
    endcase
  endfunction

  function automatic logic [63:0] gen64(input logic [63:0] other);
    int s;
    logic sg;
    s = int'($urandom_range(0, 10));
    sg = 1'($urandom);
    case (s)
      0, 1, 2: return {sg, 11'($urandom_range(1, 2046)), 20'($urandom), 32'($urandom)};
      3: return {sg, 63'd0};
      4: return {sg, 11'h7ff, 52'd0};
      5: return {sg, 11'h7ff, 1'b1, 19'($urandom), 32'($urandom)};
      6: return {sg, 11'h7ff, 1'b0, 19'($urandom), 32'($urandom) | 32'd1};
      7: return {sg, 11'h000, 20'($urandom), 32'($urandom) | 32'd1};
      8: return other;
      9: return {~other[63], other[62:0]};
      default: return {other[63:1], ~other[0]};
    endcase
  endfunction

  task automatic run_op(input string tag, input logic dm, input logic [7:0] im,
                        input logic [127:0] a, input logic [127:0] b);
    logic [127:0] er;
    bit ei, ed;
    int p;
    p = int'(im[2:0]);
    ei = 0; ed = 0; er = '0;
    if (dm) begin
      logic [63:0] x, y;
      bit xn, yn;
      x = a[63:0]; y = b[63:0];
      xn = &x[62:52] && |x[51:0];
      yn = &y[62:52] && |y[51:0];
      er = {a[127:64], {64{truth(p, xn || yn, $bitstoreal(x) < $bitstoreal(y),
                                  $bitstoreal(x) == $bitstoreal(y))}}};
      ei = (xn && !x[51]) || (yn && !y[51]) || ((xn || yn) && qinv_pred(p));
      ed = (x[62:52] == 0 && |x[51:0]) || (y[62:52] == 0 && |y[51:0]);
    end else begin
      for (int i = 0; i < 4; i++) begin
        logic [31:0] x, y;
        bit xn, yn;
        x = a[32*i +: 32]; y = b[32*i +: 32];
        xn = &x[30:23] && |x[22:0];
        yn = &y[30:23] && |y[22:0];
        er[32*i +: 32] = {32{truth(p, xn || yn, sp2r(x) < sp2r(y), sp2r(x) == sp2r(y))}};
        ei |= (xn && !x[22]) || (yn && !y[22]) || ((xn || yn) && qinv_pred(p));
        ed |= (x[30:23] == 0 && |x[22:0]) || (y[30:23] == 0 && |y[22:0]);
      end
    end
    @(negedge clk);
    dbl_mode = dm; imm = im; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " res"}, res, er);
    chk({tag, " inv"}, 128'(inv_flag), 128'(ei));
    chk({tag, " den"}, 128'(den_flag), 128'(ed));
    chk("R11 res_valid", 128'(res_valid), 128'd1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, r1;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R12 reset res", res, '0);
    chk("R12 reset valid", 128'(res_valid), '0);
    chk("R12 reset flags", 128'({inv_flag, den_flag}), '0);
    rst = 1'b0;

    // R2 signed zeros, negatives, infinities (single lanes)
    a = {32'h80000000, 32'hC0000000, 32'hFF800000, 32'h3F800000};
    b = {32'h00000000, 32'hBF800000, 32'hC0000000, 32'h7F800000};
    for (int p = 0; p < 8; p++) run_op("R2 sp order", 1'b0, 8'(p), a, b);
    // R2 doubles
    a = {64'hDEADBEEF_00000000, 64'hC000000000000000};
    b = {64'h0, 64'hBFF0000000000000};
    for (int p = 0; p < 8; p++) run_op("R2 dp order", 1'b1, 8'(p), a, b);
    // R3 R4 R5 quiet NaN under each predicate
    a = {4{32'h7FC00000}};
    b = {4{32'h3F800000}};
    for (int p = 0; p < 8; p++) run_op("R3 R4 R5 qnan", 1'b0, 8'(p), a, b);
    // R6 signaling NaN under each predicate
    a = {96'h0, 32'h3F800000};
    b = {96'h0, 32'h7F800001};
    for (int p = 0; p < 8; p++) run_op("R6 snan", 1'b0, 8'(p), a, b);
    // R7 denormal in one lane only
    run_op("R7 denorm", 1'b0, 8'd0, {32'h00000001, 96'h0}, 128'h0);
    // R9 junk above bit 63 ignored in scalar mode
    a = {32'h7F800001, 32'h00000001, 64'h3FF0000000000000};
    b = {32'h7FC00000, 32'h00000002, 64'h3FF0000000000000};
    run_op("R9 R10 upper ignored", 1'b1, 8'd1, a, b);
    // R1 upper immediate bits ignored
    a = {32'h3F800000, 32'h40000000, 32'h7FC00000, 32'h00000000};
    b = {32'h40000000, 32'h3F800000, 32'h00000000, 32'h80000000};
    run_op("R1 imm low", 1'b0, 8'h02, a, b);
    r1 = res;
    run_op("R1 imm high", 1'b0, 8'hFA, a, b);
    chk("R1 same result", res, r1);

    // random mix, R8 packed and R9 R10 scalar
    for (int n = 0; n < 600; n++) begin
      bit dm;
      dm = 1'($urandom);
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if (dm) begin
        a[63:0] = gen64(64'({$urandom, $urandom}));
        b[63:0] = gen64(a[63:0]);
      end else begin
        for (int i = 0; i < 4; i++) begin
          a[32*i +: 32] = gen32($urandom);
          b[32*i +: 32] = gen32(a[32*i +: 32]);
        end
      end
      run_op(dm ? "R9 R10 random dp" : "R8 random sp", dm, 8'($urandom), a, b);
      if (n % 50 == 0) begin
        @(negedge clk);
        chk("R11 idle valid", 128'(res_valid), '0);
      end
    end

    // R12 reset after activity
    run_op("R8 pre-reset", 1'b0, 8'd4, {4{32'h7F800001}}, {4{32'h00000003}});
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R12 mid reset res", res, '0);
    chk("R12 mid reset flags", 128'({inv_flag, den_flag, res_valid}), '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule